// File: doc/BRIEF.md
# Sectioned Angle PWM Encoder

This block turns a 12-bit angle into one pulse-width-modulated line. Every frame has a fixed number of unit times. A clock-enable tick marks each unit time. A frame has four sections in a fixed order:

- a high lead-in,
- a short field that carries the inverse of a fault flag,
- a data field whose high time equals the angle in ticks,
- a low tail.

Every frame has the same total length, so a receiver can recover the angle as a ratio of high time to frame time. The receiver can also see a fault from the level of the fault field.

The angle and the fault flag are captured once per frame, at the frame's first tick. Changes at any other time wait for the next frame. A one-cycle strobe marks the first tick of each frame so that test equipment can align to the frame. Choose the tick rate so that a frame of 4119 ticks lasts about one millisecond, which gives a PWM rate near 1 kHz.

Top module: `angle_pwm_encoder`

## Requirements
- R1: The first section of each frame lasts 12 ticks, and `pwm_out` is 1 for all of them.
- R2: The fault section follows and lasts 4 ticks. `pwm_out` equals the inverse of the captured fault flag for those ticks.
- R3: The data section follows and lasts 4095 ticks. At data position p (0 to 4094), `pwm_out` is 1 when p is less than the captured angle and 0 otherwise.
- R4: The tail section lasts 8 ticks with `pwm_out` at 0. A frame is 4119 ticks in total, and the next frame starts with the lead-in right after it.
- R5: When the captured fault flag is 1, `pwm_out` is 0 for the whole data section, whatever the angle.
- R6: An angle of 4095 keeps `pwm_out` at 1 for every data tick. An angle of 0 keeps it at 0 for every data tick.
- R7: `angle_in` and `err_in` are sampled only on the first tick of a frame. Changes at any other time do not affect the current frame.
- R8: `frame_start` is 1 for exactly one clock cycle, the cycle after the first tick of a frame is taken. It is 0 at all other times.
- R9: The outputs change only on the clock edge that follows a cycle with `tick_en` high. Each tick's level appears on the edge that takes that tick.
- R10: While `rst` is high, `pwm_out` and `frame_start` are 0. The first tick after reset begins a new frame at the lead-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Unit-time enable; one frame position per high cycle |
| angle_in | input | 12 | Angle to encode |
| err_in | input | 1 | System fault flag |
| pwm_out | output | 1 | Encoded PWM line |
| frame_start | output | 1 | One-cycle strobe at the first tick of a frame |

## Verification
The assertions assume that `tick_en` is a plain level sampled on each rising edge, and that the angle and fault inputs are stable at that edge. They do not assume any spacing between ticks or any hold time of the inputs across a frame.

The stimulus changes every input only on falling edges. It uses two tick patterns: a tick on every cycle, and a tick on every third cycle. It moves the angle and fault flag in the middle of frames, so the capture point is exercised. It also applies one reset in the middle of a frame.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  typedef enum logic [1:0] {
    SEC_LEAD = 2'd0,
    SEC_FLT  = 2'd1,
    SEC_DATA = 2'd2,
    SEC_TAIL = 2'd3
  } sec_t;
endpackage

// File: rtl/apwm_sequencer.sv
module apwm_sequencer
  import apwm_pkg::*;
#(
  parameter int ANGLE_W    = 12,
  parameter int LEAD_TICKS = 12,
  parameter int FLT_TICKS  = 4,
  parameter int TAIL_TICKS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  output sec_t               sec_o,
  output logic [ANGLE_W-1:0] pos_o,
  output logic               first_o
);
  localparam int DATA_TICKS = (1 << ANGLE_W) - 1;
  localparam logic [ANGLE_W-1:0] LEAD_LAST = ANGLE_W'(LEAD_TICKS - 1);
  localparam logic [ANGLE_W-1:0] FLT_LAST  = ANGLE_W'(FLT_TICKS - 1);
  localparam logic [ANGLE_W-1:0] DATA_LAST = ANGLE_W'(DATA_TICKS - 1);
  localparam logic [ANGLE_W-1:0] TAIL_LAST = ANGLE_W'(TAIL_TICKS - 1);

  sec_t               sec_q;
  logic [ANGLE_W-1:0] pos_q;
  logic [ANGLE_W-1:0] last;
  sec_t               sec_nx;

  always_comb begin
    unique case (sec_q)
      SEC_LEAD: begin last = LEAD_LAST; sec_nx = SEC_FLT;  end
      SEC_FLT:  begin last = FLT_LAST;  sec_nx = SEC_DATA; end
      SEC_DATA: begin last = DATA_LAST; sec_nx = SEC_TAIL; end
      default:  begin last = TAIL_LAST; sec_nx = SEC_LEAD; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= SEC_LEAD;
      pos_q <= '0;
    end else if (tick_en) begin
      if (pos_q == last) begin
        sec_q <= sec_nx;
        pos_q <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign sec_o   = sec_q;
  assign pos_o   = pos_q;
  assign first_o = (sec_q == SEC_LEAD) && (pos_q == '0);

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_en && sec_q == SEC_TAIL && pos_q == TAIL_LAST) |=> (sec_q == SEC_LEAD && pos_q == '0));
  assert_lead_to_flt_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_en && sec_q == SEC_LEAD && pos_q == LEAD_LAST) |=> (sec_q == SEC_FLT && pos_q == '0));
  assert_hold_pos_R9: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(pos_q) && $stable(sec_q)));
endmodule

// File: rtl/apwm_level.sv
module apwm_level
  import apwm_pkg::*;
#(
  parameter int ANGLE_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  sec_t               sec_i,
  input  logic [ANGLE_W-1:0] pos_i,
  input  logic               first_i,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               err_i,
  output logic               pwm_o,
  output logic               strobe_o
);
  logic [ANGLE_W-1:0] angle_q;
  logic               err_q;
  logic               level;

  always_comb begin
    unique case (sec_i)
      SEC_LEAD: level = 1'b1;
      SEC_FLT:  level = ~err_q;
      SEC_DATA: level = ~err_q && (pos_i < angle_q);
      default:  level = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      angle_q  <= '0;
      err_q    <= 1'b0;
      pwm_o    <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= tick_en && first_i;
      if (tick_en) begin
        pwm_o <= level;
        if (first_i) begin
          angle_q <= angle_i;
          err_q   <= err_i;
        end
      end
    end
  end

  assert_lead_high_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_en && sec_i == SEC_LEAD) |=> pwm_o);
  assert_tail_low_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_en && sec_i == SEC_TAIL) |=> !pwm_o);
  assert_fault_blanks_R5: assert property (@(posedge clk) disable iff (rst)
    (tick_en && sec_i == SEC_DATA && err_q) |=> !pwm_o);
  assert_pwm_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(pwm_o));
  assert_capture_only_first_R7: assert property (@(posedge clk) disable iff (rst)
    !(tick_en && first_i) |=> ($stable(angle_q) && $stable(err_q)));
endmodule

// File: rtl/angle_pwm_encoder.sv
module angle_pwm_encoder
  import apwm_pkg::*;
#(
  parameter int ANGLE_W    = 12,
  parameter int LEAD_TICKS = 12,
  parameter int FLT_TICKS  = 4,
  parameter int TAIL_TICKS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic [ANGLE_W-1:0] angle_in,
  input  logic               err_in,
  output logic               pwm_out,
  output logic               frame_start
);
  sec_t               sec;
  logic [ANGLE_W-1:0] pos;
  logic               first;

  apwm_sequencer #(
    .ANGLE_W(ANGLE_W), .LEAD_TICKS(LEAD_TICKS),
    .FLT_TICKS(FLT_TICKS), .TAIL_TICKS(TAIL_TICKS)
  ) i_seq (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .sec_o(sec), .pos_o(pos), .first_o(first)
  );

  apwm_level #(.ANGLE_W(ANGLE_W)) i_lvl (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .sec_i(sec), .pos_i(pos), .first_i(first),
    .angle_i(angle_in), .err_i(err_in),
    .pwm_o(pwm_out), .strobe_o(frame_start)
  );

  assert_strobe_with_lead_R8: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> pwm_out);
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!pwm_out && !frame_start));
endmodule

// File: tb/test_angle_pwm_encoder.sv
module test_angle_pwm_encoder;
  localparam int FRAME = 4119;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [11:0] angle_in = '0;
  logic        err_in = 1'b0;
  logic        pwm_out, frame_start;

  int checks = 0;
  int errors = 0;
  int div = 1;
  int divcnt = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // reference model state
  int    pos = 0;
  int    m_angle = 0;
  bit    m_err = 1'b0;
  bit    e_pwm = 1'b0;
  bit    e_fs = 1'b0;
  string e_tag = "R10";

  always #5 clk = ~clk;

  angle_pwm_encoder i_angle_pwm_encoder (
    .clk(clk), .rst(rst), .tick_en(tick_en), .angle_in(angle_in),
    .err_in(err_in), .pwm_out(pwm_out), .frame_start(frame_start)
  );

  always @(posedge clk) begin
    if (rst) begin
      pos = 0; e_pwm = 0; e_fs = 0; e_tag = "R10";
    end else if (tick_en) begin
      if (pos == 0) begin m_angle = angle_in; m_err = err_in; end
      if (pos < 12) begin e_pwm = 1; e_tag = "R1"; end
      else if (pos < 16) begin e_pwm = !m_err; e_tag = "R2"; end
      else if (pos < 4111) begin
        e_pwm = !m_err && ((pos - 16) < m_angle);
        e_tag = m_err ? "R5" : ((m_angle == 0 || m_angle == 4095) ? "R6" : "R3");
      end else begin e_pwm = 0; e_tag = "R4"; end
      e_fs = (pos == 0);
      pos = (pos + 1) % FRAME;
    end else begin
      e_fs = 0; e_tag = "R9";
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (pwm_out !== e_pwm) begin
        errors++;
        $display("FAIL %s pwm_out actual=%b expected=%b pos=%0d", e_tag, pwm_out, e_pwm, pos);
      end
      checks++;
      if (frame_start !== e_fs) begin
        errors++;
        $display("FAIL R8 frame_start actual=%b expected=%b (%s)", frame_start, e_fs, e_tag);
      end
    end
    divcnt++;
    tick_en = (divcnt % div) == 0;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    checks++;
    if (pwm_out !== 1'b0 || frame_start !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset outputs actual=%b%b expected=00", pwm_out, frame_start);
    end
    cmp_on = 1'b1;
    angle_in = 12'd1000;
    rst = 1'b0;
    wait_cyc(FRAME + 50);
    angle_in = 12'd0;                  // R6 empty data, R7 picked up next frame
    wait_cyc(FRAME);
    angle_in = 12'd4095;               // R6 full data
    wait_cyc(FRAME);
    err_in = 1'b1; angle_in = 12'd2000; // R5, R2
    wait_cyc(FRAME);
    err_in = 1'b0; angle_in = 12'd1;
    wait_cyc(FRAME / 2);
    for (int k = 0; k < 40; k++) begin // R7 mid-frame churn
      angle_in = 12'(k * 97); err_in = k[0];
      wait_cyc(50);
    end
    err_in = 1'b0; angle_in = 12'd3000;
    wait_cyc(FRAME);
    rst = 1'b1;                        // R10 mid-frame reset
    wait_cyc(2);
    checks++;
    if (pwm_out !== 1'b0) begin
      errors++;
      $display("FAIL R10 pwm_out during reset actual=%b expected=0", pwm_out);
    end
    rst = 1'b0; angle_in = 12'd17;
    wait_cyc(FRAME + 20);
    div = 3; angle_in = 12'd2500;      // R9 sparse ticks
    wait_cyc(3 * FRAME + 30);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule